// File: doc/BRIEF.md
# Feed-Protected Clock Multiplier Control Registers

This block is the register front end of an on-chip clock multiplier. Software writes a control word (enable and connect bits) and a configuration word (multiplier and post-divider codes) into staging registers over a simple word-addressed bus. None of these writes changes the clock hardware directly. The staged pair is copied into the active registers only when the feed register receives the key 0xAA and then the key 0x55 as the next bus access. This guards the clock against stray or runaway writes.

The active settings drive the enable, multiplier and divider outputs. A behavioural lock model asserts the lock flag a fixed, parameterised number of reference cycles after the multiplier is enabled with a configuration whose oscillator frequency lies inside the allowed window. The oscillator frequency is reference × (multiplier code + 1) × 2 × 2^divider code. The connect output, which selects the multiplied clock as the system clock, follows lock. A read-only status word reflects the applied settings and the lock flag. The usual sequence is: stage the configuration with enable set, feed, poll the status lock bit, then stage enable plus connect and feed again.

Top module: `pll_feed_regs`

## Requirements
- R1: After reset, the staging registers, the active registers, the status word and all PLL outputs are zero.
- R2: The bus decodes the word index `bus_addr[3:2]`: 0 is control (bit 0 enable, bit 1 connect), 1 is configuration (bits 4:0 multiplier code, bits 6:5 divider code), 2 is status (read-only) and 3 is feed. Reads of control and configuration return the staged values. Staged writes leave the outputs and status unchanged until a valid feed.
- R3: A write of 0xAA to feed, followed by a write of 0x55 to feed as the next bus access (idle cycles between them are allowed), copies both staged registers into the active registers on the clock edge that takes the 0x55 write.
- R4: A read or write of any other register, or a write of any other value to feed, between the two keys aborts the sequence. The active registers do not change and the staged values stay pending for a later valid feed.
- R5: Status bits 6:0 hold the applied configuration, bit 8 the applied enable, bit 9 the applied connect and bit 10 the lock flag. All other bits read zero, so an enabled, unlocked PLL with configuration 0x23 reads 0x0123.
- R6: When a feed applies enable with an in-range configuration that differs from the previous one, or enables a previously disabled PLL, lock rises exactly LOCK_CYCLES clock edges after the feed edge.
- R7: A configuration whose oscillator frequency lies outside [OSC_MIN_KHZ, OSC_MAX_KHZ] never locks. With the default 14746 kHz reference, 0x03 (about 118 MHz) and 0x25 (about 354 MHz) are out of range, and 0x23 and 0x24 are in range.
- R8: `pll_connect` is high only while the applied enable, the applied connect and lock are all high.
- R9: A feed that clears enable drops lock and connect on the feed edge. A feed that changes only the connect bit keeps an existing lock.
- R10: `pll_mult` and `pll_div` carry the applied configuration bits 4:0 and 6:5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (counts as an access for feed abort) |
| bus_addr | input | 4 | Byte offset; bits 3:2 select the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the selected register (combinational) |
| pll_en | output | 1 | Applied enable |
| pll_connect | output | 1 | Multiplied clock selected as system clock |
| pll_mult | output | 5 | Applied multiplier code (multiplier minus one) |
| pll_div | output | 2 | Applied post-divider code |
| pll_locked | output | 1 | Lock flag from the behavioural lock model |

## Verification
The assertions check the following on every cycle. Connect never appears without enable and lock. The active registers move only on a completed feed. A completed feed always has a 0xAA key as the previous access. Lock never coexists with an out-of-range configuration or a cleared enable. Lock only rises after an enabled, in-range cycle. The exact lock delay, the staged values surviving an aborted sequence, the status encodings and the retention of lock across a connect-only feed are history-dependent outcomes. Only the bench's directed scenarios show these.

// File: rtl/pll_regs_pkg.sv
package pll_regs_pkg;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_CFG  = 2'd1,
    REG_STAT = 2'd2,
    REG_FEED = 2'd3
  } reg_sel_e;

  localparam int CTRL_W   = 2;
  localparam int CFG_W    = 7;
  localparam int MSEL_W   = 5;
  localparam int PSEL_W   = 2;
  localparam logic [7:0] KEY_FIRST  = 8'hAA;
  localparam logic [7:0] KEY_SECOND = 8'h55;

  // Oscillator frequency in kHz: ref * (msel+1) * 2 * 2^psel
  function automatic logic [31:0] osc_khz(input logic [31:0] ref_khz,
                                          input logic [CFG_W-1:0] cfg);
    logic [31:0] mult;
    mult = 32'(cfg[MSEL_W-1:0]) + 32'd1;
    return (ref_khz * mult * 32'd2) << cfg[CFG_W-1:MSEL_W];
  endfunction

  function automatic logic cfg_in_range(input logic [31:0] ref_khz,
                                        input logic [31:0] lo_khz,
                                        input logic [31:0] hi_khz,
                                        input logic [CFG_W-1:0] cfg);
    logic [31:0] f;
    f = osc_khz(ref_khz, cfg);
    return (f >= lo_khz) && (f <= hi_khz);
  endfunction

  function automatic logic [31:0] pack_status(input logic [CFG_W-1:0] cfg,
                                              input logic [CTRL_W-1:0] ctrl,
                                              input logic locked);
    logic [31:0] s;
    s = '0;
    s[CFG_W-1:0] = cfg;
    s[8]  = ctrl[0];
    s[9]  = ctrl[1];
    s[10] = locked;
    return s;
  endfunction

endpackage

// File: rtl/pll_feed_seq.sv
module pll_feed_seq
  import pll_regs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc,
  input  logic       wr,
  input  reg_sel_e   sel,
  input  logic [7:0] wdata,
  output logic       armed,
  output logic       feed_ok
);
  logic feed_wr;
  assign feed_wr = wr && (sel == REG_FEED);
  assign feed_ok = armed && feed_wr && (wdata == KEY_SECOND);

  // Every access re-evaluates: only a first-key write to feed leaves it armed
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   armed <= 1'b0;
    else if (acc) armed <= feed_wr && (wdata == KEY_FIRST);
  end
endmodule

// File: rtl/pll_reg_bank.sv
module pll_reg_bank
  import pll_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  reg_sel_e          sel,
  input  logic [31:0]       wdata,
  input  logic              apply,
  output logic [CTRL_W-1:0] shd_ctrl,
  output logic [CFG_W-1:0]  shd_cfg,
  output logic [CTRL_W-1:0] act_ctrl,
  output logic [CFG_W-1:0]  act_cfg
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd_ctrl <= '0;
      shd_cfg  <= '0;
    end else if (wr) begin
      if (sel == REG_CTRL) shd_ctrl <= wdata[CTRL_W-1:0];
      if (sel == REG_CFG)  shd_cfg  <= wdata[CFG_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_ctrl <= '0;
      act_cfg  <= '0;
    end else if (apply) begin
      act_ctrl <= shd_ctrl;
      act_cfg  <= shd_cfg;
    end
  end
endmodule

// File: rtl/pll_lock_timer.sv
module pll_lock_timer #(
  parameter int LOCK_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic locked
);
  localparam int CW = $clog2(LOCK_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(LOCK_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      locked <= 1'b0;
    end else if (!run || restart) begin
      cnt    <= '0;
      locked <= 1'b0;
    end else if (!locked) begin
      if (cnt == LAST) locked <= 1'b1;
      else             cnt    <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pll_feed_regs.sv
module pll_feed_regs
  import pll_regs_pkg::*;
#(
  parameter int REF_KHZ     = 14746,
  parameter int OSC_MIN_KHZ = 156000,
  parameter int OSC_MAX_KHZ = 320000,
  parameter int LOCK_CYCLES = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [3:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        pll_en,
  output logic        pll_connect,
  output logic [4:0]  pll_mult,
  output logic [1:0]  pll_div,
  output logic        pll_locked
);
  reg_sel_e          sel;
  logic              bus_acc;
  logic              feed_armed;
  logic              feed_ok;
  logic [CTRL_W-1:0] shd_ctrl, act_ctrl;
  logic [CFG_W-1:0]  shd_cfg, act_cfg;
  logic              cfg_ok;
  logic              lock_run;
  logic              lock_restart;
  logic [31:0]       status_word;

  assign sel     = reg_sel_e'(bus_addr[3:2]);
  assign bus_acc = bus_wr || bus_rd;

  pll_feed_seq i_feed (
    .clk(clk), .rst_n(rst_n), .acc(bus_acc), .wr(bus_wr), .sel(sel),
    .wdata(bus_wdata[7:0]), .armed(feed_armed), .feed_ok(feed_ok)
  );

  pll_reg_bank i_bank (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .sel(sel), .wdata(bus_wdata),
    .apply(feed_ok), .shd_ctrl(shd_ctrl), .shd_cfg(shd_cfg),
    .act_ctrl(act_ctrl), .act_cfg(act_cfg)
  );

  assign cfg_ok   = cfg_in_range(32'(REF_KHZ), 32'(OSC_MIN_KHZ), 32'(OSC_MAX_KHZ), act_cfg);
  assign lock_run = act_ctrl[0] && cfg_ok;
  // Restart lock when the applied frequency changes or enable is being dropped
  assign lock_restart = feed_ok && ((shd_cfg != act_cfg) || !shd_ctrl[0]);

  pll_lock_timer #(.LOCK_CYCLES(LOCK_CYCLES)) i_lock (
    .clk(clk), .rst_n(rst_n), .run(lock_run), .restart(lock_restart),
    .locked(pll_locked)
  );

  assign status_word = pack_status(act_cfg, act_ctrl, pll_locked);

  always_comb begin
    unique case (sel)
      REG_CTRL: bus_rdata = 32'(shd_ctrl);
      REG_CFG:  bus_rdata = 32'(shd_cfg);
      REG_STAT: bus_rdata = status_word;
      default:  bus_rdata = '0;
    endcase
  end

  assign pll_en      = act_ctrl[0];
  assign pll_connect = act_ctrl[0] && act_ctrl[1] && pll_locked;
  assign pll_mult    = act_cfg[MSEL_W-1:0];
  assign pll_div     = act_cfg[CFG_W-1:MSEL_W];
endmodule

// File: rtl/pll_feed_regs_chk.sv
module pll_feed_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr,
  input logic        bus_rd,
  input logic [3:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic        feed_ok,
  input logic        cfg_ok,
  input logic [1:0]  act_ctrl,
  input logic [6:0]  act_cfg,
  input logic        pll_en,
  input logic        pll_connect,
  input logic        pll_locked
);
  // Independent tracker: was the last bus access a first-key write to feed?
  logic last_was_key1;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_was_key1 <= 1'b0;
    else if (bus_wr || bus_rd)
      last_was_key1 <= bus_wr && (bus_addr[3:2] == 2'd3) && (bus_wdata[7:0] == 8'hAA);
  end

  assert_connect_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pll_connect |-> (pll_locked && pll_en));

  assert_apply_only_on_feed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !feed_ok |=> ($stable(act_cfg) && $stable(act_ctrl)));

  assert_feed_follows_key_R4: assert property (@(posedge clk) disable iff (!rst_n)
    feed_ok |-> last_was_key1);

  assert_no_lock_out_of_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_ok |-> !pll_locked);

  assert_no_lock_when_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !pll_en |-> !pll_locked);

  assert_lock_rise_needs_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_locked) |-> $past(pll_en && cfg_ok));
endmodule

bind pll_feed_regs pll_feed_regs_chk i_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .feed_ok(feed_ok),
  .cfg_ok(cfg_ok), .act_ctrl(act_ctrl), .act_cfg(act_cfg),
  .pll_en(pll_en), .pll_connect(pll_connect), .pll_locked(pll_locked)
);

// File: tb/test_pll_feed_regs.sv
module test_pll_feed_regs;
  localparam int CLK_PERIOD  = 10;
  localparam int LOCK_CYCLES = 16;
  localparam logic [3:0] A_CTRL = 4'h0, A_CFG = 4'h4, A_STAT = 4'h8, A_FEED = 4'hC;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        pll_en, pll_connect, pll_locked;
  logic [4:0]  pll_mult;
  logic [1:0]  pll_div;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pll_feed_regs #(.LOCK_CYCLES(LOCK_CYCLES)) i_pll_feed_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pll_en(pll_en), .pll_connect(pll_connect), .pll_mult(pll_mult),
    .pll_div(pll_div), .pll_locked(pll_locked)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #(CLK_PERIOD/4);
    d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic feed();
    bus_write(A_FEED, 32'hAA);
    bus_write(A_FEED, 32'h55);
  endtask

  task automatic expect_status(input string tag, input logic [31:0] exp);
    logic [31:0] d;
    bus_read(A_STAT, d);
    check(tag, d, exp);
  endtask

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 outputs after reset", {pll_en, pll_connect, pll_locked, pll_mult, pll_div}, 0);
    expect_status("R1 status after reset", 32'h0);
    bus_read(A_CFG, d);
    check("R1 staged cfg after reset", d, 32'h0);
  endtask

  task automatic t_staging();
    logic [31:0] d;
    bus_write(A_CFG, 32'h23);
    bus_write(A_CTRL, 32'h1);
    bus_read(A_CFG, d);  check("R2 staged cfg readback", d, 32'h23);
    bus_read(A_CTRL, d); check("R2 staged ctrl readback", d, 32'h1);
    check("R2 enable untouched before feed", pll_en, 0);
    expect_status("R2 status untouched before feed", 32'h0);
  endtask

  task automatic t_aborts();
    logic [31:0] d;
    bus_write(A_FEED, 32'hAA); bus_write(A_CTRL, 32'h1); bus_write(A_FEED, 32'h55);
    check("R4 other-register write aborts", {pll_en, 2'b0, pll_mult}, 0);
    bus_write(A_FEED, 32'hAA); bus_write(A_FEED, 32'h56); bus_write(A_FEED, 32'h55);
    check("R4 wrong key aborts", {pll_en, 2'b0, pll_mult}, 0);
    bus_write(A_FEED, 32'hAA); bus_read(A_CFG, d); bus_write(A_FEED, 32'h55);
    check("R4 read between keys aborts", {pll_en, 2'b0, pll_mult}, 0);
    expect_status("R4 status after aborts", 32'h0);
  endtask

  task automatic t_apply_and_lock();
    feed();
    check("R3 enable applied on feed edge", pll_en, 1);
    check("R10 multiplier code", pll_mult, 5'd3);
    check("R10 divider code", pll_div, 2'd1);
    check("R6 not locked right after feed", pll_locked, 0);
    wait_cycles(LOCK_CYCLES - 1);
    check("R6 not locked one cycle early", pll_locked, 0);
    wait_cycles(1);
    check("R6 locked after LOCK_CYCLES", pll_locked, 1);
    check("R8 no connect without connect bit", pll_connect, 0);
    expect_status("R5 status enabled and locked", 32'h0523);
  endtask

  task automatic t_unlocked_status();
    bus_write(A_CFG, 32'h24);
    feed();
    expect_status("R5 status enabled unlocked", 32'h0124);
    wait_cycles(LOCK_CYCLES);
    check("R7 in-range 0x24 locks", pll_locked, 1);
    bus_write(A_CFG, 32'h23);
    feed();
    wait_cycles(LOCK_CYCLES + 1);
  endtask

  task automatic t_connect_disable();
    bus_write(A_CTRL, 32'h3);
    check("R8 connect waits for feed", pll_connect, 0);
    feed();
    check("R8 connect after feed when locked", pll_connect, 1);
    check("R9 connect-only feed keeps lock", pll_locked, 1);
    expect_status("R5 status with connect", 32'h0723);
    bus_write(A_CTRL, 32'h0);
    feed();
    check("R9 disable drops connect", pll_connect, 0);
    check("R9 disable drops lock", pll_locked, 0);
    expect_status("R9 status after disable", 32'h0023);
  endtask

  task automatic t_out_of_range();
    bus_write(A_CFG, 32'h03); bus_write(A_CTRL, 32'h1); feed();
    expect_status("R7 status for 0x03", 32'h0103);
    wait_cycles(3 * LOCK_CYCLES);
    check("R7 0x03 never locks", pll_locked, 0);
    bus_write(A_CFG, 32'h25); feed();
    wait_cycles(3 * LOCK_CYCLES);
    check("R7 0x25 never locks", pll_locked, 0);
    bus_write(A_CFG, 32'h44); feed();
    check("R10 divider code 2", pll_div, 2'd2);
    check("R10 multiplier code 4", pll_mult, 5'd4);
    wait_cycles(3 * LOCK_CYCLES);
    check("R7 0x44 never locks", pll_locked, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 3 + 1);
    rst_n = 1'b1;
    t_reset();
    t_staging();
    t_aborts();
    t_apply_and_lock();
    t_unlocked_status();
    t_connect_disable();
    t_out_of_range();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule